// File: doc/BRIEF.md
# Four-Channel APB Countdown Timer

This peripheral holds several independent down-counters behind one APB slave. Each channel occupies a 64-byte address window. In that window software picks a run mode, writes a preset, starts or stops the counter, forces the preset back into the counter, reads the live count, and manages a pending interrupt flag and its mask. Every channel drives its own interrupt line, and that line is high when the flag is pending and the mask is open.

A channel counts down by one per clock while it runs. When it is running and sits at zero, it expires on the next clock. In continuous mode an expiry raises the pending flag and puts the preset back into the counter, so the period is preset + 1 clocks. In single-shot mode an expiry raises the flag, leaves the count at zero and stops the channel. To clear the flag, software writes 1 to the status register. The clear is followed by a fixed busy interval, and further clear writes are dropped until it ends.

APB transfers complete with no wait states. A write takes effect at the clock edge of its access phase. Read data is combinational during the transfer.

Top module: `apb_multi_timer`

## Requirements
- R1: Channel n sits at byte address n*0x40. Its registers are at these offsets: 0x04 run mode (bit 0), 0x08 preset, 0x10 run enable (bit 0), 0x14 reload strobe, 0x18 live count (read only), 0x1C status (bit 0 pending, bit 1 busy), 0x20 interrupt mask (bit 0). After reset every register reads 0 except the mask, which reads 1.
- R2: While a channel runs with a nonzero count, the count drops by exactly one per clock, and the live count register shows it.
- R3: Writing 1 to the run enable of a stopped channel copies the preset into the counter and starts it. Writing 0 freezes the count.
- R4: A write of any data to the reload strobe copies the preset into the counter at that edge, whether the channel runs or not.
- R5: Run mode 0 is continuous. A running channel at zero sets pending and reloads the preset on that clock, so expiries come every preset + 1 clocks.
- R6: Run mode 1 is single-shot. A running channel at zero sets pending, clears its own run enable and keeps the count at zero.
- R7: A channel's interrupt output equals pending AND NOT mask.
- R8: Writing 1 to status bit 0 clears pending and holds busy at 1 for exactly 3 clocks. Writing 0 to it changes nothing.
- R9: A status write that lands while busy is 1 is ignored, and pending keeps its value.
- R10: If an expiry and an accepted clear fall on the same edge, pending stays 1 and busy still starts.
- R11: Channels are independent: an expiry on one channel raises only that channel's interrupt bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1, no wait states |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
An expiry and an interrupt clear can land on the same clock edge, and the design gives the expiry priority. The bench starts a single-shot channel with a preset of 1 and issues the clear write right after the enable write, so the clear's access edge is the expiry edge. A status read is then expected to return both pending and busy. A second case places an expiry inside the busy window and follows it with a clear that must be dropped. The bench confirms that pending survives.

// File: rtl/apb_tmr_pkg.sv
package apb_tmr_pkg;

    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_MODE = 6'h04;
    localparam logic [OFS_W-1:0] OFS_LOAD = 6'h08;
    localparam logic [OFS_W-1:0] OFS_ENA  = 6'h10;
    localparam logic [OFS_W-1:0] OFS_RLD  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_VAL  = 6'h18;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_MASK = 6'h20;

    typedef enum logic {
        RUN_CONT   = 1'b0,
        RUN_SINGLE = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic mode;
        logic load;
        logic ena;
        logic rld;
        logic stat;
        logic mask;
    } tmr_wr_t;

    function automatic tmr_wr_t decode_wr(input logic hit, input logic [OFS_W-1:0] ofs);
        tmr_wr_t w;
        w = '0;
        if (hit) begin
            case (ofs)
                OFS_MODE: w.mode = 1'b1;
                OFS_LOAD: w.load = 1'b1;
                OFS_ENA:  w.ena  = 1'b1;
                OFS_RLD:  w.rld  = 1'b1;
                OFS_STAT: w.stat = 1'b1;
                OFS_MASK: w.mask = 1'b1;
                default:  w = '0;
            endcase
        end
        return w;
    endfunction

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import apb_tmr_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int ADDR_W = 8,
    parameter int CH_W   = 2
) (
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    output tmr_wr_t [NCH-1:0]    wr_o,
    output logic [CH_W-1:0]      ch_o,
    output logic [OFS_W-1:0]     ofs_o,
    output logic                 ch_valid_o
);

    logic wr_acc;

    assign ofs_o      = paddr[OFS_W-1:0];
    assign ch_o       = paddr[OFS_W +: CH_W];
    assign ch_valid_o = ({1'b0, ch_o} < (CH_W+1)'(NCH));
    assign wr_acc     = psel && penable && pwrite && ch_valid_o;

    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign wr_o[g] = decode_wr(wr_acc && (ch_o == CH_W'(g)), ofs_o);
    end

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import apb_tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter int BUSY_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  tmr_wr_t           wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int BC_W = $clog2(BUSY_CYC + 1);

    run_mode_e        mode_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             pend_q;
    logic             mask_q;
    logic [BC_W-1:0]  busy_cnt;
    logic             busy;
    logic             expire;
    logic             start;
    logic             clr_ok;

    assign busy   = (busy_cnt != '0);
    assign expire = en_q && (cnt_q == '0);
    assign start  = wr.ena && wdata[0] && !en_q;
    assign clr_ok = wr.stat && wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RUN_CONT;
            load_q <= '0;
            mask_q <= 1'b1;
        end else begin
            if (wr.mode) mode_q <= run_mode_e'(wdata[0]);
            if (wr.load) load_q <= wdata[CNT_W-1:0];
            if (wr.mask) mask_q <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (wr.ena)
                en_q <= wdata[0];
            else if (expire && mode_q == RUN_SINGLE)
                en_q <= 1'b0;

            if (wr.rld || start)
                cnt_q <= load_q;
            else if (expire) begin
                if (mode_q == RUN_CONT) cnt_q <= load_q;
            end else if (en_q)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            busy_cnt <= '0;
        end else begin
            if (expire)
                pend_q <= 1'b1;
            else if (clr_ok)
                pend_q <= 1'b0;

            if (clr_ok)
                busy_cnt <= BC_W'(BUSY_CYC);
            else if (busy)
                busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign irq = pend_q && !mask_q;

    always_comb begin
        rdata = '0;
        case (rd_ofs)
            OFS_MODE: rdata[0]   = mode_q;
            OFS_LOAD: rdata      = DATA_W'(load_q);
            OFS_ENA:  rdata[0]   = en_q;
            OFS_VAL:  rdata      = DATA_W'(cnt_q);
            OFS_STAT: rdata[1:0] = {busy, pend_q};
            OFS_MASK: rdata[0]   = mask_q;
            default:  rdata      = '0;
        endcase
    end

    assert_count_down_R2: assert property (@(posedge clk) disable iff (rst)
        (en_q && cnt_q != '0 && !wr.rld && !wr.ena) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_reload_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        wr.rld |=> (cnt_q == $past(load_q)));

    assert_single_stops_R6: assert property (@(posedge clk) disable iff (rst)
        (en_q && cnt_q == '0 && mode_q == RUN_SINGLE && !wr.ena) |=> (!en_q && cnt_q == '0 && pend_q));

    assert_clear_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (wr.stat && wdata[0] && !busy && !(en_q && cnt_q == '0)) |=> (!pend_q && busy));

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (rst)
        (wr.stat && busy && pend_q) |=> pend_q);

    assert_expiry_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (en_q && cnt_q == '0 && wr.stat && wdata[0] && !busy) |=> (pend_q && busy));

endmodule

// File: rtl/apb_multi_timer.sv
module apb_multi_timer
    import apb_tmr_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 32,
    parameter int BUSY_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic [NCH-1:0]    irq
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    tmr_wr_t [NCH-1:0] wr;
    logic [CH_W-1:0]   ch_sel;
    logic [OFS_W-1:0]  ofs;
    logic              ch_valid;
    logic [DATA_W-1:0] ch_rd [NCH];

    tmr_regdec #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .wr_o       (wr),
        .ch_o       (ch_sel),
        .ofs_o      (ofs),
        .ch_valid_o (ch_valid)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_chan (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr[g]),
            .wdata  (pwdata),
            .rd_ofs (ofs),
            .rdata  (ch_rd[g]),
            .irq    (irq[g])
        );
    end

    assign pready = 1'b1;
    assign prdata = (psel && ch_valid) ? ch_rd[ch_sel] : '0;

endmodule

// File: tb/apb_multi_timer_tb.sv
module apb_multi_timer_tb;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    apb_multi_timer u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .irq(irq)
    );

    localparam logic [7:0] A_MODE = 8'h04, A_LOAD = 8'h08, A_ENA = 8'h10, A_RLD = 8'h14,
                           A_VAL = 8'h18, A_STAT = 8'h1C, A_MASK = 8'h20;

    function automatic logic [7:0] ad(input int ch, input logic [7:0] ofs);
        return 8'(ch * 64) + ofs;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic apb_wr(input int ch, input logic [7:0] ofs, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = ad(ch, ofs); pwdata = d;
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        @(posedge clk); @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input int ch, input logic [7:0] ofs, output logic [31:0] d);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = ad(ch, ofs);
        @(posedge clk); @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(posedge clk); @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    task automatic wait_irq(input int idx, output int n);
        n = 0;
        while (!irq[idx] && n < 100) begin
            @(posedge clk); @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R7 irq after reset", 32'(irq), 32'h0);
        for (int c = 0; c < NCH; c++) begin
            apb_rd(c, A_MASK, d); check("R1 mask reset", d, 32'h1);
            apb_rd(c, A_VAL, d);  check("R1 count reset", d, 32'h0);
            apb_rd(c, A_STAT, d); check("R1 status reset", d, 32'h0);
        end
    endtask

    task automatic t_count();
        logic [31:0] d, e;
        apb_wr(0, A_LOAD, 32'd100);
        apb_rd(0, A_LOAD, d); check("R1 preset readback", d, 32'd100);
        apb_wr(0, A_ENA, 32'h1);
        apb_rd(0, A_VAL, d); check("R3 start loads then R2 count", d, 32'd99);
        apb_rd(0, A_VAL, d); check("R2 count after 3", d, 32'd97);
        apb_wr(0, A_ENA, 32'h0);
        apb_rd(0, A_VAL, d);
        apb_rd(0, A_VAL, e); check("R3 stop freezes", e, d);
        apb_wr(0, A_LOAD, 32'd77);
        apb_wr(0, A_RLD, 32'h1234);
        apb_rd(0, A_VAL, d); check("R4 reload strobe", d, 32'd77);
    endtask

    task automatic t_cont();
        logic [31:0] d;
        int n;
        apb_wr(1, A_LOAD, 32'd5);
        apb_wr(1, A_MASK, 32'h0);
        apb_wr(1, A_ENA, 32'h1);
        wait_irq(1, n);
        check("R5 period preset+1", 32'(n), 32'd6);
        check("R11 only channel 1 irq", 32'(irq), 32'h2);
        apb_rd(1, A_VAL, d); check("R5 reload on expiry", d, 32'd4);
        apb_wr(1, A_ENA, 32'h0);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        apb_wr(2, A_STAT, 32'h1);
        apb_rd(2, A_STAT, d); check("R8 busy one clock after clear", d, 32'h2);
        apb_rd(2, A_STAT, d); check("R8 busy gone three clocks after", d, 32'h0);
        idle(2);
        apb_wr(2, A_STAT, 32'h1);
        idle(1);
        apb_rd(2, A_STAT, d); check("R8 busy two clocks after clear", d, 32'h2);
        idle(3);
    endtask

    task automatic t_single();
        logic [31:0] d;
        int n;
        apb_wr(3, A_MODE, 32'h1);
        apb_wr(3, A_LOAD, 32'd3);
        apb_wr(3, A_MASK, 32'h0);
        apb_wr(3, A_ENA, 32'h1);
        wait_irq(3, n);
        check("R6 single expiry time", 32'(n), 32'd4);
        apb_rd(3, A_ENA, d); check("R6 enable self clears", d, 32'h0);
        apb_rd(3, A_VAL, d); check("R6 count held at zero", d, 32'h0);
        apb_wr(3, A_STAT, 32'h0);
        apb_rd(3, A_STAT, d); check("R8 write 0 no effect", d, 32'h1);
        check("R7 irq with open mask", 32'(irq[3]), 32'h1);
        apb_wr(3, A_MASK, 32'h1);
        check("R7 irq masked", 32'(irq[3]), 32'h0);
        apb_wr(3, A_MASK, 32'h0);
        apb_wr(3, A_STAT, 32'h1);
        check("R8 clear drops irq", 32'(irq[3]), 32'h0);
        idle(5);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        apb_wr(3, A_LOAD, 32'd1);
        apb_wr(3, A_ENA, 32'h1);
        apb_wr(3, A_STAT, 32'h1);
        apb_rd(3, A_STAT, d); check("R10 expiry beats clear", d, 32'h3);
        idle(6);
        apb_wr(3, A_STAT, 32'h1);
        idle(6);
        apb_wr(3, A_LOAD, 32'd2);
        apb_wr(3, A_ENA, 32'h1);
        apb_wr(3, A_STAT, 32'h1);
        apb_wr(3, A_STAT, 32'h1);
        apb_rd(3, A_STAT, d); check("R9 clear during busy ignored", d, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_count();
        t_cont();
        t_busy();
        t_single();
        t_collide();
        check("R11 pready tied high", 32'(pready), 32'h1);
        report();
    end

endmodule